// File: doc/BRIEF.md
# Stream Destination Remapper

This block sits inline on an AXI-Stream path and changes nothing but the 16-bit routing destination (`tdest`) of the packets that pass through it. The payload, byte enables, end-of-packet marker and the valid/ready handshake go straight through, so the block adds no cycles and no storage to the data path.

The new destination comes from a table of ternary rules. Each rule compares the incoming destination against a value under a mask. When a rule hits, a second value/mask pair is merged into the destination bit by bit: bits under the rewrite mask take the rule's value, and every other bit keeps its incoming state. When no rule hits, a default value/mask pair is applied in the same way. The lookup is made on the first beat of a packet, and its result is held for every later beat of that packet. Software programs the table through an AXI4-Lite slave. After reset every register is zero, and the block then behaves as a plain wire.

Top module: `tdest_remapper`

## Requirements
- R1: `m_tdata`, `m_tkeep`, `m_tlast` and `m_tvalid` equal `s_tdata`, `s_tkeep`, `s_tlast` and `s_tvalid` in the same cycle, and `s_tready` equals `m_tready`. No bubble is ever inserted.
- R2: After reset, reading byte offset 0x000 returns the identity word 0xD57A310F: bits [31:8] hold the fixed tag 0xD57A31 and bits [7:0] hold the rule count 15. With the tables at their reset value of zero, `m_tdest` equals `s_tdest`.
- R3: The register layout is as follows. Offset 0x004 is the default pair, with the mask in [31:16] and the value in [15:0]. Rule i (0..14) has its match pair at 0x008+8·i and its rewrite pair at 0x00C+8·i, in the same layout. Written words read back unchanged. Writes to 0x000 are ignored. Offsets from 0x080 upward read as zero and ignore writes.
- R4: Rule i hits when (tdest & match_mask) == (match_value & match_mask).
- R5: Rule i takes part in the lookup only when both its match mask and its rewrite mask are non-zero. A rule with either mask at zero never hits.
- R6: When several enabled rules hit, the rule with the lowest index decides.
- R7: The outgoing destination is (tdest & ~rewrite_mask) | (rewrite_value & rewrite_mask), using the pair of the rule that decides.
- R8: When no enabled rule hits, the default pair at 0x004 is applied with the formula of R7.
- R9: The result is computed from the destination of the first beat of a packet and is driven on every beat of that packet. The destination inputs of later beats, and table writes made while the packet is open, do not change it. The held result is released once the beat carrying `tlast` is accepted.
- R10: Every write and read response is OKAY (code 0). `bvalid` and `rvalid` stay high, and `rdata` stays stable, until they are accepted. Each bit of `wstrb` enables its byte lane of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_awaddr | input | ADDR_W | Write byte address |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte enables |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_bresp | output | 2 | Write response code |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_araddr | input | ADDR_W | Read byte address |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response code |
| s_tvalid | input | 1 | Upstream beat valid |
| s_tready | output | 1 | Upstream ready |
| s_tdata | input | DATA_W | Upstream payload |
| s_tkeep | input | DATA_W/8 | Upstream byte enables |
| s_tlast | input | 1 | Upstream end of packet |
| s_tdest | input | 16 | Upstream destination |
| m_tvalid | output | 1 | Downstream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | DATA_W | Downstream payload |
| m_tkeep | output | DATA_W/8 | Downstream byte enables |
| m_tlast | output | 1 | Downstream end of packet |
| m_tdest | output | 16 | Rewritten destination |

## Verification
The lookup is tried with four kinds of table. The reset table separates a true wire from a block that rewrites anyway. A rule hitting under a partial mask separates the bit merge from a whole-word replacement. Tables holding several overlapping hits, or rules with only one mask set, separate lowest-index priority and the two-mask enable from the other orderings and enable rules. Multi-beat packets with random destinations on later beats, random downstream stalls and a table write made mid-packet separate a result held per packet from one looked up on every beat, and also show when the held result is released. Random tables and packets drawn around the programmed match values then compare every beat against a bench model.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int unsigned DEST_W = 16;

    typedef struct packed {
        logic [DEST_W-1:0] mask;
        logic [DEST_W-1:0] value;
    } pair_t;

    function automatic logic [DEST_W-1:0] merge_dest(input logic [DEST_W-1:0] dest,
                                                     input pair_t p);
        return (dest & ~p.mask) | (p.value & p.mask);
    endfunction

    function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  strb);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/tdr_regfile.sv
module tdr_regfile
    import tdr_pkg::*;
#(
    parameter int unsigned N_ENT   = 15,
    parameter int unsigned ADDR_W  = 12,
    parameter logic [23:0] ID_TAG  = 24'hD57A31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  wvalid,
    output logic                  wready,
    input  logic [31:0]           wdata,
    input  logic [3:0]            wstrb,
    output logic                  bvalid,
    input  logic                  bready,
    input  logic                  arvalid,
    output logic                  arready,
    input  logic [ADDR_W-1:0]     araddr,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [31:0]           rdata,
    output pair_t [N_ENT-1:0]     match_o,
    output pair_t [N_ENT-1:0]     trans_o,
    output pair_t                 dflt_o
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    typedef struct packed {
        pair_t [N_ENT-1:0] mt;
        pair_t [N_ENT-1:0] tr;
        pair_t             dflt;
        logic              bvalid;
        logic              rvalid;
        logic [31:0]       rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [WIDX_W-1:0] widx, ridx;
    logic              wr_fire, rd_fire;
    logic              unused_addr_lsb;

    assign widx            = awaddr[ADDR_W-1:2];
    assign ridx            = araddr[ADDR_W-1:2];
    assign unused_addr_lsb = ^{awaddr[1:0], araddr[1:0]};
    assign wr_fire         = awvalid && wvalid && !regs_q.bvalid;
    assign rd_fire         = arvalid && !regs_q.rvalid;

    always_comb begin
        regs_d = regs_q;
        if (regs_q.bvalid && bready) regs_d.bvalid = 1'b0;
        if (regs_q.rvalid && rready) regs_d.rvalid = 1'b0;

        if (wr_fire) begin
            regs_d.bvalid = 1'b1;
            if (widx == WIDX_W'(1))
                regs_d.dflt = byte_merge(regs_q.dflt, wdata, wstrb);
            for (int i = 0; i < int'(N_ENT); i++) begin
                if (widx == WIDX_W'(2 + 2*i))
                    regs_d.mt[i] = byte_merge(regs_q.mt[i], wdata, wstrb);
                if (widx == WIDX_W'(3 + 2*i))
                    regs_d.tr[i] = byte_merge(regs_q.tr[i], wdata, wstrb);
            end
        end

        if (rd_fire) begin
            regs_d.rvalid = 1'b1;
            regs_d.rdata  = '0;
            if (ridx == WIDX_W'(0)) regs_d.rdata = {ID_TAG, 8'(N_ENT)};
            if (ridx == WIDX_W'(1)) regs_d.rdata = regs_q.dflt;
            for (int i = 0; i < int'(N_ENT); i++) begin
                if (ridx == WIDX_W'(2 + 2*i)) regs_d.rdata = regs_q.mt[i];
                if (ridx == WIDX_W'(3 + 2*i)) regs_d.rdata = regs_q.tr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign bvalid  = regs_q.bvalid;
    assign arready = !regs_q.rvalid;
    assign rvalid  = regs_q.rvalid;
    assign rdata   = regs_q.rdata;
    assign match_o = regs_q.mt;
    assign trans_o = regs_q.tr;
    assign dflt_o  = regs_q.dflt;
endmodule

// File: rtl/tdr_lookup.sv
module tdr_lookup
    import tdr_pkg::*;
#(
    parameter int unsigned N_ENT = 15
) (
    input  logic [DEST_W-1:0]  dest_i,
    input  pair_t [N_ENT-1:0]  match_i,
    input  pair_t [N_ENT-1:0]  trans_i,
    input  pair_t              dflt_i,
    output logic [DEST_W-1:0]  dest_o
);
    logic [N_ENT-1:0] hit;

    for (genvar g = 0; g < N_ENT; g++) begin : g_rule
        logic enabled;
        assign enabled = (|match_i[g].mask) && (|trans_i[g].mask);
        assign hit[g]  = enabled &&
                         ((dest_i & match_i[g].mask) == (match_i[g].value & match_i[g].mask));
    end

    pair_t chosen;
    always_comb begin
        chosen = dflt_i;
        for (int i = int'(N_ENT) - 1; i >= 0; i--)
            if (hit[i]) chosen = trans_i[i];
    end

    assign dest_o = merge_dest(dest_i, chosen);
endmodule

// File: rtl/tdr_hold.sv
module tdr_hold
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_ok,
    input  logic              last_i,
    input  logic [DEST_W-1:0] fresh_i,
    output logic [DEST_W-1:0] dest_o
);
    typedef struct packed {
        logic              open;
        logic [DEST_W-1:0] held;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (beat_ok) begin
            if (last_i) begin
                hold_d.open = 1'b0;
            end else if (!hold_q.open) begin
                hold_d.open = 1'b1;
                hold_d.held = fresh_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign dest_o = hold_q.open ? hold_q.held : fresh_i;
endmodule

// File: rtl/tdest_remapper.sv
module tdest_remapper
    import tdr_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_ENT  = 15,
    localparam int unsigned KEEP_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_axil_awvalid,
    output logic              s_axil_awready,
    input  logic [ADDR_W-1:0] s_axil_awaddr,
    input  logic              s_axil_wvalid,
    output logic              s_axil_wready,
    input  logic [31:0]       s_axil_wdata,
    input  logic [3:0]        s_axil_wstrb,
    output logic              s_axil_bvalid,
    input  logic              s_axil_bready,
    output logic [1:0]        s_axil_bresp,
    input  logic              s_axil_arvalid,
    output logic              s_axil_arready,
    input  logic [ADDR_W-1:0] s_axil_araddr,
    output logic              s_axil_rvalid,
    input  logic              s_axil_rready,
    output logic [31:0]       s_axil_rdata,
    output logic [1:0]        s_axil_rresp,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [KEEP_W-1:0] s_tkeep,
    input  logic              s_tlast,
    input  logic [15:0]       s_tdest,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [KEEP_W-1:0] m_tkeep,
    output logic              m_tlast,
    output logic [15:0]       m_tdest
);
    pair_t [N_ENT-1:0] match_w, trans_w;
    pair_t             dflt_w;
    logic [DEST_W-1:0] fresh_w;

    tdr_regfile #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_axil_awvalid), .awready(s_axil_awready), .awaddr(s_axil_awaddr),
        .wvalid(s_axil_wvalid), .wready(s_axil_wready), .wdata(s_axil_wdata), .wstrb(s_axil_wstrb),
        .bvalid(s_axil_bvalid), .bready(s_axil_bready),
        .arvalid(s_axil_arvalid), .arready(s_axil_arready), .araddr(s_axil_araddr),
        .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata),
        .match_o(match_w), .trans_o(trans_w), .dflt_o(dflt_w)
    );

    tdr_lookup #(.N_ENT(N_ENT)) i_lookup (
        .dest_i(s_tdest), .match_i(match_w), .trans_i(trans_w),
        .dflt_i(dflt_w), .dest_o(fresh_w)
    );

    tdr_hold i_hold (
        .clk(clk), .rst_n(rst_n),
        .beat_ok(s_tvalid && m_tready), .last_i(s_tlast),
        .fresh_i(fresh_w), .dest_o(m_tdest)
    );

    assign s_axil_bresp = 2'b00;
    assign s_axil_rresp = 2'b00;
    assign m_tvalid     = s_tvalid;
    assign s_tready     = m_tready;
    assign m_tdata      = s_tdata;
    assign m_tkeep      = s_tkeep;
    assign m_tlast      = s_tlast;
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned KEEP_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_axil_bvalid,
    input logic              s_axil_bready,
    input logic [1:0]        s_axil_bresp,
    input logic              s_axil_rvalid,
    input logic              s_axil_rready,
    input logic [31:0]       s_axil_rdata,
    input logic [1:0]        s_axil_rresp,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic [DATA_W-1:0] s_tdata,
    input logic [KEEP_W-1:0] s_tkeep,
    input logic              s_tlast,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [KEEP_W-1:0] m_tkeep,
    input logic              m_tlast,
    input logic [15:0]       m_tdest
);
    logic        open_q;
    logic [15:0] first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            first_q <= '0;
        end else if (s_tvalid && m_tready) begin
            if (s_tlast) open_q <= 1'b0;
            else if (!open_q) begin
                open_q  <= 1'b1;
                first_q <= m_tdest;
            end
        end
    end

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid == s_tvalid) && (m_tdata == s_tdata) && (m_tkeep == s_tkeep)
        && (m_tlast == s_tlast) && (s_tready == m_tready));

    p_held_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && s_tvalid) |-> (m_tdest == first_q));

    p_bresp_okay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_axil_bvalid |-> (s_axil_bresp == 2'b00));

    p_rresp_okay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_axil_rvalid |-> (s_axil_rresp == 2'b00));

    p_bvalid_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axil_bvalid && !s_axil_bready) |=> s_axil_bvalid);

    p_rdata_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_axil_rvalid && !s_axil_rready) |=> (s_axil_rvalid && $stable(s_axil_rdata)));
endmodule

bind tdest_remapper tdr_checker #(.DATA_W(DATA_W)) i_tdr_checker (
    .clk(clk), .rst_n(rst_n),
    .s_axil_bvalid(s_axil_bvalid), .s_axil_bready(s_axil_bready), .s_axil_bresp(s_axil_bresp),
    .s_axil_rvalid(s_axil_rvalid), .s_axil_rready(s_axil_rready),
    .s_axil_rdata(s_axil_rdata), .s_axil_rresp(s_axil_rresp),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tlast(s_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tdest(m_tdest)
);

// File: tb/test_tdest_remapper.sv
module test_tdest_remapper;
    localparam int DATA_W = 64;
    localparam int KEEP_W = DATA_W / 8;
    localparam int ADDR_W = 12;
    localparam int N_ENT  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  wstrb = '0;
    logic [1:0]  bresp, rresp;
    logic s_tvalid = 0, s_tlast = 0, m_tready = 0;
    logic s_tready, m_tvalid, m_tlast;
    logic [DATA_W-1:0] s_tdata = '0, m_tdata;
    logic [KEEP_W-1:0] s_tkeep = '0, m_tkeep;
    logic [15:0] s_tdest = '0, m_tdest;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    logic [31:0] mdl_match [N_ENT];
    logic [31:0] mdl_trans [N_ENT];
    logic [31:0] mdl_dflt;

    always #10 clk = ~clk;

    tdest_remapper #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ENT(N_ENT)) i_tdest_remapper (
        .clk(clk), .rst_n(rst_n),
        .s_axil_awvalid(awvalid), .s_axil_awready(awready), .s_axil_awaddr(awaddr),
        .s_axil_wvalid(wvalid), .s_axil_wready(wready), .s_axil_wdata(wdata), .s_axil_wstrb(wstrb),
        .s_axil_bvalid(bvalid), .s_axil_bready(bready), .s_axil_bresp(bresp),
        .s_axil_arvalid(arvalid), .s_axil_arready(arready), .s_axil_araddr(araddr),
        .s_axil_rvalid(rvalid), .s_axil_rready(rready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tlast(s_tlast), .s_tdest(s_tdest),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
        .m_tlast(m_tlast), .m_tdest(m_tdest)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input logic ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] apply_pair(input logic [15:0] d, input logic [31:0] p);
        return (d & ~p[31:16]) | (p[15:0] & p[31:16]);
    endfunction

    function automatic logic [15:0] exp_dest(input logic [15:0] d);
        logic [31:0] pick;
        logic found;
        pick  = mdl_dflt;
        found = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found && mdl_match[i][31:16] != 0 && mdl_trans[i][31:16] != 0 &&
                ((d & mdl_match[i][31:16]) == (mdl_match[i][15:0] & mdl_match[i][31:16]))) begin
                pick  = mdl_trans[i];
                found = 1'b1;
            end
        end
        return apply_pair(d, pick);
    endfunction

    task automatic axil_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                              input logic [3:0] s);
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        while (!bvalid) @(negedge clk);
        check(bresp == 2'b00, "R10 write response", 64'(bresp), 64'd0);
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axil_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        arvalid = 1; araddr = a;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        // hold rready low one cycle: data must not move
        d = rdata;
        @(negedge clk);
        check(rvalid && rdata == d, "R10 read data held until accepted", 64'(rdata), 64'(d));
        check(rresp == 2'b00, "R10 read response", 64'(rresp), 64'd0);
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic set_rule(input int i, input logic [31:0] m, input logic [31:0] t);
        axil_write(ADDR_W'(8 + 8*i), m, 4'hF);
        axil_write(ADDR_W'(12 + 8*i), t, 4'hF);
        mdl_match[i] = m;
        mdl_trans[i] = t;
    endtask

    task automatic set_dflt(input logic [31:0] p);
        axil_write(ADDR_W'(4), p, 4'hF);
        mdl_dflt = p;
    endtask

    task automatic clear_table();
        for (int i = 0; i < N_ENT; i++) set_rule(i, 32'h0, 32'h0);
        set_dflt(32'h0);
    endtask

    // Send one packet; later beats carry random tdest. mid_write pokes the table
    // after the first beat is accepted (R9).
    task automatic send_pkt(input int len, input logic [15:0] dest, input string tag,
                            input logic mid_write);
        logic [15:0] want;
        int b;
        want = exp_dest(dest);
        b = 0;
        while (b < len) begin
            @(negedge clk);
            s_tvalid = 1;
            s_tdata  = {$urandom, $urandom};
            s_tkeep  = KEEP_W'($urandom);
            s_tlast  = (b == len - 1);
            s_tdest  = (b == 0) ? dest : 16'($urandom);
            m_tready = ($urandom % 4) != 0;
            #1;
            check(m_tvalid && m_tdata == s_tdata && m_tkeep == s_tkeep &&
                  m_tlast == s_tlast && s_tready == m_tready,
                  "R1 pass-through", {m_tkeep, 55'(m_tdata)}, {s_tkeep, 55'(s_tdata)});
            check(m_tdest == want, tag, 64'(m_tdest), 64'(want));
            @(posedge clk);
            if (m_tready) begin
                b++;
                if (b == 1 && mid_write && len > 1) begin
                    @(negedge clk);
                    s_tvalid = 0;
                    set_rule(0, 32'hFFFF_0000 | 32'(dest), 32'hFFFF_0ABC);
                end
            end
        end
        @(negedge clk);
        s_tvalid = 0; s_tlast = 0; m_tready = 0;
    endtask

    logic [31:0] rd;
    logic [15:0] pool [8];

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < N_ENT; i++) begin mdl_match[i] = 0; mdl_trans[i] = 0; end
        mdl_dflt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: identity word and wire behaviour at reset
        axil_read(12'h000, rd);
        check(rd == 32'hD57A310F, "R2 identity word", 64'(rd), 64'hD57A310F);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            s_tvalid = 1; s_tlast = 1; s_tdest = 16'($urandom); m_tready = 1;
            #1;
            check(m_tdest == s_tdest, "R2 reset pass-through dest", 64'(m_tdest), 64'(s_tdest));
        end
        @(negedge clk); s_tvalid = 0; s_tlast = 0;

        // R3: layout, readback, read-only ident, out-of-range
        axil_write(12'h000, 32'h1234_5678, 4'hF);
        axil_read(12'h000, rd);
        check(rd == 32'hD57A310F, "R3 identity ignores writes", 64'(rd), 64'hD57A310F);
        set_rule(14, 32'h00F0_0030, 32'h0F00_0500);
        axil_read(12'h07C, rd);
        check(rd == 32'h0F00_0500, "R3 rule 14 rewrite readback", 64'(rd), 64'h0F000500);
        axil_read(12'h078, rd);
        check(rd == 32'h00F0_0030, "R3 rule 14 match readback", 64'(rd), 64'h00F00030);
        axil_write(12'h080, 32'hFFFF_FFFF, 4'hF);
        axil_read(12'h080, rd);
        check(rd == 32'h0, "R3 beyond table reads zero", 64'(rd), 64'h0);
        send_pkt(2, 16'h1234, "R4 rule 14 hit rewrites bits 11:8", 1'b0);
        check(exp_dest(16'h1234) == 16'h1534, "R7 model sanity", 64'(exp_dest(16'h1234)), 64'h1534);

        // R10: byte lanes
        set_dflt(32'hAAAA_BBBB);
        axil_write(12'h004, 32'h1111_2222, 4'b0011);
        mdl_dflt = 32'hAAAA_2222;
        axil_read(12'h004, rd);
        check(rd == 32'hAAAA_2222, "R10 wstrb byte lanes", 64'(rd), 64'hAAAA2222);

        // R8: miss takes default
        clear_table();
        set_dflt(32'hFF00_5A00);
        send_pkt(3, 16'h0077, "R8 miss uses default pair", 1'b0);

        // R5: half-enabled rules never hit
        set_rule(0, 32'hFFFF_4444, 32'h0000_9999);
        set_rule(1, 32'h0000_4444, 32'hFFFF_1111);
        set_rule(3, 32'hFFFF_4444, 32'h000F_0003);
        send_pkt(1, 16'h4444, "R5 only rule 3 enabled, expect 4443", 1'b0);

        // R6: lowest index among hits
        set_rule(2, 32'hF000_4000, 32'h00F0_0020);
        send_pkt(2, 16'h4444, "R6 rule 2 beats rule 3, expect 4424", 1'b0);

        // R9: hold through mid-packet table change, then release
        clear_table();
        set_rule(5, 32'hFF00_2200, 32'hFFFF_0F0F);
        send_pkt(4, 16'h22AB, "R9 held result across beats", 1'b1);
        send_pkt(2, 16'h22AB, "R9 released: next packet sees new rule 0", 1'b0);

        // random tables and packets (R4 R6 R7 R8 R9)
        for (int round = 0; round < 12; round++) begin
            clear_table();
            for (int p = 0; p < 8; p++) pool[p] = 16'($urandom);
            for (int e = 0; e < N_ENT; e++) begin
                if (($urandom % 3) != 0) begin
                    logic [15:0] mm, tm;
                    mm = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom);
                    tm = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom);
                    set_rule(e, {mm, pool[$urandom % 8]}, {tm, 16'($urandom)});
                end
            end
            set_dflt($urandom);
            for (int k = 0; k < 12; k++) begin
                logic [15:0] d;
                d = pool[$urandom % 8] ^ (($urandom % 2) ? 16'(1 << ($urandom % 16)) : 16'h0);
                send_pkt(1 + int'($urandom % 4), d, "R7 random beat vs model", 1'b0);
            end
        end

        finish_run();
    end
endmodule